// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a watchdog for catching software that has stopped running. A 14-bit counter is loaded with a start value chosen by static option inputs and counts down on ticks from a selectable clock source. The source is the system clock divided by 2, 16 or 128, or a low-speed oscillator tick divided by 16. Software keeps the counter from running out by writing a two-byte key to the key register: first 00h, then FFh. The key is accepted only while the count sits inside a refresh window set by another option field. If the counter runs out, the block raises either a one-cycle interrupt or a one-cycle reset request. A reset request also reinitialises the whole block on the next cycle.

A protection mode can be on from reset, or software can turn it on. Once on, software cannot turn it off until the next reset. In protection mode the counter runs from the undivided low-speed tick and does not stop in low-power mode, and running out always requests a reset. All clocks are modelled as enable ticks in one clock domain. Option inputs are expected to stay constant while the block is out of reset.

Top module: `winwdt_top`

## Requirements
- R1: After reset the count equals the start value set by `opt_init_sel_i` (00: 03FFh, 01: 0FFFh, 10: 1FFFh, 11: 3FFFh), and `irq_o` and `rst_req_o` are low.
- R2: With `opt_autostart_i`=1 counting begins right after reset. Otherwise the count holds until any write to the start register (address 1).
- R3: Without protection, the control register (address 2) bits [1:0] pick the source: 00 system clock/2, 01 system clock/16, 10 system clock/128, 11 `ls_tick_i`/16. The dividers restart from zero when counting starts, so k clock edges after the start write (or after reset with auto-start) the count has dropped by floor(k/divisor).
- R4: Without protection, a system-clock source freezes the count while `low_power_i` is high, and the divider phase is kept. The low-speed source keeps counting in low-power mode.
- R5: Control bit 2 at 0 selects interrupt mode. A tick at count zero then gives a one-cycle `irq_o` pulse, reloads the start value, and counting continues.
- R6: Control bit 2 at 1 selects reset mode. A tick at count zero then gives a one-cycle `rst_req_o` pulse. On the following edge every register returns to its reset state, including the running state, the control register and the protection mode.
- R7: In protection mode the count drops by one on every `ls_tick_i` cycle, whatever the value of control bits [1:0] or `low_power_i`, and running out always gives `rst_req_o` and never `irq_o`.
- R8: Protection is on after reset when `opt_prot_i`=1. A control write with bit 3 set turns it on, and a later control write with bit 3 clear does not turn it off. Only a reset clears it.
- R9: At the key register (address 0), a 00h write arms the key and a following FFh write reloads the start value. A second byte other than FFh disarms the key without reloading. An FFh write that is not armed is ignored. A repeated 00h leaves the key armed.
- R10: The window is open while the count is below (start+1)/4 × (N+1), where N is `opt_win_sel_i` (00: 25%, 01: 50%, 10: 75%, 11: always open). A key completed at or above that limit does not reload.
- R11: A key write made while the window is closed disarms the key. An FFh written after the window opens does not reload unless a new 00h came first.
- R12: Writes to address 3, and control bits [7:4], have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ls_tick_i | input | 1 | One-cycle enable per low-speed oscillator period |
| low_power_i | input | 1 | High while the system is in a low-power mode |
| opt_autostart_i | input | 1 | Static option: start counting after reset |
| opt_prot_i | input | 1 | Static option: protection mode on after reset |
| opt_init_sel_i | input | 2 | Static option: counter start value |
| opt_win_sel_i | input | 2 | Static option: refresh window size |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address: 0 key, 1 start, 2 control |
| wr_data_i | input | 8 | Register write data |
| cnt_o | output | 14 | Current counter value |
| irq_o | output | 1 | One-cycle underflow interrupt |
| rst_req_o | output | 1 | One-cycle reset request |

## Verification
A register write takes effect at the clock edge where the write strobe is high. A refresh reload, a start or a control change can be seen on the outputs half a cycle later. A source tick changes `cnt_o` at that same edge. An underflow shows `irq_o` or `rst_req_o` right after the edge that took the tick at zero, and the reinitialised count appears one edge after `rst_req_o` goes high. The bench drives inputs and samples outputs on the falling edge. For each check it counts the rising edges that have passed since the stimulus and works out the expected value from that count, using floor(k/divisor) for the prescaled sources.

// File: rtl/winwdt_pkg.sv
// Package winwdt_pkg
// Shared encodings for the windowed watchdog: register addresses,
// clock-source selections, control bit positions and key bytes.
// Assumes an 8-bit or wider write data bus.
package winwdt_pkg;

    typedef enum logic [1:0] {
        SRC_SYS_D2   = 2'b00,
        SRC_SYS_D16  = 2'b01,
        SRC_SYS_D128 = 2'b10,
        SRC_LS_D16   = 2'b11
    } src_sel_e;

    typedef enum logic [1:0] {
        REG_KEY   = 2'd0,
        REG_START = 2'd1,
        REG_CTRL  = 2'd2,
        REG_SPARE = 2'd3
    } reg_addr_e;

    localparam int CTRL_SRC_LSB  = 0;
    localparam int CTRL_UFL_RST  = 2;
    localparam int CTRL_PROT_SET = 3;
    localparam int CTRL_USED_W   = 4;

endpackage

// File: rtl/winwdt_regs.sv
// Module winwdt_regs
// Holds the control register (source select, underflow action), the
// sticky protection flag and the running flag. Decodes writes to the
// start and control addresses. rst_n here is the block-level reset,
// which also covers the watchdog's own reset request.
module winwdt_regs
    import winwdt_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              opt_autostart,
    input  logic              opt_prot,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output src_sel_e          src_sel,
    output logic              ufl_rst,
    output logic              prot,
    output logic              running
);

    logic ctrl_wr;
    logic start_wr;
    logic unused_ctrl_bits;

    assign ctrl_wr  = wr_en && (wr_addr == ADDR_W'(REG_CTRL));
    assign start_wr = wr_en && (wr_addr == ADDR_W'(REG_START));
    assign unused_ctrl_bits = ^wr_data[DATA_W-1:CTRL_USED_W];

    // Control register: source select and underflow action.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_sel <= SRC_SYS_D2;
            ufl_rst <= 1'b0;
        end else if (ctrl_wr) begin
            src_sel <= src_sel_e'(wr_data[CTRL_SRC_LSB +: 2]);
            ufl_rst <= wr_data[CTRL_UFL_RST];
        end
    end

    // Protection flag: loaded from the option, set-only by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prot <= opt_prot;
        end else if (ctrl_wr && wr_data[CTRL_PROT_SET]) begin
            prot <= 1'b1;
        end
    end

    // Running flag: auto-start option or first start-register write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= opt_autostart;
        end else if (start_wr) begin
            running <= 1'b1;
        end
    end

endmodule

// File: rtl/winwdt_prescaler.sv
// Module winwdt_prescaler
// Produces one count tick per enabled period of the selected source.
// The system-clock divider and the low-speed divider both restart at
// zero while the watchdog is not running. In protection mode the raw
// low-speed tick is passed through and low-power mode is ignored.
module winwdt_prescaler
    import winwdt_pkg::*;
#(
    parameter int DIV_A_LOG  = 1,
    parameter int DIV_B_LOG  = 4,
    parameter int DIV_C_LOG  = 7,
    parameter int LS_DIV_LOG = 4
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     running,
    input  logic     prot,
    input  logic     low_power,
    input  src_sel_e src_sel,
    input  logic     ls_tick,
    output logic     cnt_tick
);

    localparam int PRE_W = DIV_C_LOG;
    localparam logic [PRE_W-1:0] MASK_A = PRE_W'((1 << DIV_A_LOG) - 1);
    localparam logic [PRE_W-1:0] MASK_B = PRE_W'((1 << DIV_B_LOG) - 1);
    localparam logic [PRE_W-1:0] MASK_C = PRE_W'((1 << DIV_C_LOG) - 1);

    logic [PRE_W-1:0]      pre_cnt;
    logic [LS_DIV_LOG-1:0] ls_cnt;
    logic [PRE_W-1:0]      pre_mask;
    logic                  ls_src;
    logic                  sys_active;
    logic                  sys_tick;
    logic                  ls_div_tick;
    logic                  prot_tick;

    // Divider mask for the selected system-clock ratio.
    always_comb begin
        case (src_sel)
            SRC_SYS_D2:  pre_mask = MASK_A;
            SRC_SYS_D16: pre_mask = MASK_B;
            default:     pre_mask = MASK_C;
        endcase
    end

    assign ls_src      = (src_sel == SRC_LS_D16);
    assign sys_active  = running && !prot && !ls_src && !low_power;
    assign sys_tick    = sys_active && ((pre_cnt & pre_mask) == pre_mask);
    assign ls_div_tick = running && !prot && ls_src && ls_tick && (ls_cnt == '1);
    assign prot_tick   = running && prot && ls_tick;
    assign cnt_tick    = sys_tick || ls_div_tick || prot_tick;

    // System-clock divider, frozen in low-power mode.
    always_ff @(posedge clk) begin
        if (!rst_n || !running) begin
            pre_cnt <= '0;
        end else if (sys_active) begin
            pre_cnt <= pre_cnt + PRE_W'(1);
        end
    end

    // Low-speed divider, advanced by each oscillator tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !running) begin
            ls_cnt <= '0;
        end else if (ls_tick && !prot && ls_src) begin
            ls_cnt <= ls_cnt + LS_DIV_LOG'(1);
        end
    end

endmodule

// File: rtl/winwdt_keyseq.sv
// Module winwdt_keyseq
// Tracks the two-byte refresh key at the key address. An arm byte inside
// the window arms the sequence. The fire byte while armed and inside the
// window gives a one-cycle refresh. Any other key write disarms.
// Writes to other addresses leave the armed state alone.
module winwdt_keyseq
    import winwdt_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              win_open,
    output logic              refresh
);

    localparam logic [DATA_W-1:0] KEY_ARM  = '0;
    localparam logic [DATA_W-1:0] KEY_FIRE = '1;

    logic key_wr;
    logic armed;

    assign key_wr  = wr_en && (wr_addr == ADDR_W'(REG_KEY));
    assign refresh = key_wr && win_open && armed && (wr_data == KEY_FIRE);

    // Armed state: set only by an in-window arm byte, cleared by any other key write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
        end else if (key_wr) begin
            armed <= win_open && (wr_data == KEY_ARM);
        end
    end

endmodule

// File: rtl/winwdt_core.sv
// Module winwdt_core
// The down counter and the underflow outputs. A refresh reloads the
// count and takes priority over a tick. A tick at zero is an underflow:
// the count reloads, and either the interrupt or the reset request is
// pulsed for one cycle. The reset request flop uses only the external
// reset, so it can clear itself after one cycle.
module winwdt_core #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             blk_rst_n,
    input  logic             cnt_tick,
    input  logic             refresh,
    input  logic             rst_mode,
    input  logic [CNT_W-1:0] init_val,
    output logic [CNT_W-1:0] cnt_o,
    output logic             irq_o,
    output logic             rst_req_o
);

    logic ufl;

    assign ufl = cnt_tick && (cnt_o == '0) && !refresh;

    // Counter: reload on reset or refresh, otherwise decrement per tick.
    always_ff @(posedge clk) begin
        if (!blk_rst_n) begin
            cnt_o <= init_val;
        end else if (refresh) begin
            cnt_o <= init_val;
        end else if (cnt_tick) begin
            cnt_o <= (cnt_o == '0) ? init_val : cnt_o - CNT_W'(1);
        end
    end

    // Interrupt pulse on underflow in interrupt mode.
    always_ff @(posedge clk) begin
        if (!blk_rst_n) begin
            irq_o <= 1'b0;
        end else begin
            irq_o <= ufl && !rst_mode;
        end
    end

    // Reset-request pulse on underflow in reset mode, self-clearing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_req_o <= 1'b0;
        end else if (rst_req_o) begin
            rst_req_o <= 1'b0;
        end else begin
            rst_req_o <= ufl && rst_mode;
        end
    end

endmodule

// File: rtl/winwdt_top.sv
// Module winwdt_top
// Windowed watchdog top. Derives the start value and the refresh window
// limit from the static options, and forms the block reset from the
// external reset and the block's own reset request. It then connects the
// register, prescaler, key and counter pieces. Option inputs are assumed
// static while out of reset.
module winwdt_top
    import winwdt_pkg::*;
#(
    parameter int CNT_W     = 14,
    parameter int DATA_W    = 8,
    parameter int ADDR_W    = 2,
    parameter int INIT_LOG0 = 10,
    parameter int INIT_LOG1 = 12,
    parameter int INIT_LOG2 = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ls_tick_i,
    input  logic              low_power_i,
    input  logic              opt_autostart_i,
    input  logic              opt_prot_i,
    input  logic [1:0]        opt_init_sel_i,
    input  logic [1:0]        opt_win_sel_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              irq_o,
    output logic              rst_req_o
);

    localparam int LIM_W = CNT_W + 1;

    logic [CNT_W-1:0] init_val;
    logic [LIM_W-1:0] quarter;
    logic [LIM_W-1:0] win_limit;
    logic             win_open;
    logic             blk_rst_n;
    src_sel_e         presc_sel;
    logic             ufl_rst;
    logic             prot;
    logic             running;
    logic             cnt_tick;
    logic             refresh;

    // Start value chosen by the option field.
    always_comb begin
        case (opt_init_sel_i)
            2'b00:   init_val = CNT_W'((1 << INIT_LOG0) - 1);
            2'b01:   init_val = CNT_W'((1 << INIT_LOG1) - 1);
            2'b10:   init_val = CNT_W'((1 << INIT_LOG2) - 1);
            default: init_val = '1;
        endcase
    end

    // Window limit as one to four quarters of the count range.
    always_comb begin
        quarter = ({1'b0, init_val} + LIM_W'(1)) >> 2;
        case (opt_win_sel_i)
            2'b00:   win_limit = quarter;
            2'b01:   win_limit = quarter << 1;
            2'b10:   win_limit = (quarter << 1) + quarter;
            default: win_limit = quarter << 2;
        endcase
    end

    assign win_open  = ({1'b0, cnt_o} < win_limit);
    assign blk_rst_n = rst_n && !rst_req_o;

    winwdt_regs #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) regs_i (
        .clk           (clk),
        .rst_n         (blk_rst_n),
        .opt_autostart (opt_autostart_i),
        .opt_prot      (opt_prot_i),
        .wr_en         (wr_en_i),
        .wr_addr       (wr_addr_i),
        .wr_data       (wr_data_i),
        .src_sel       (presc_sel),
        .ufl_rst       (ufl_rst),
        .prot          (prot),
        .running       (running)
    );

    winwdt_prescaler prescaler_i (
        .clk       (clk),
        .rst_n     (blk_rst_n),
        .running   (running),
        .prot      (prot),
        .low_power (low_power_i),
        .src_sel   (presc_sel),
        .ls_tick   (ls_tick_i),
        .cnt_tick  (cnt_tick)
    );

    winwdt_keyseq #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) keyseq_i (
        .clk      (clk),
        .rst_n    (blk_rst_n),
        .wr_en    (wr_en_i),
        .wr_addr  (wr_addr_i),
        .wr_data  (wr_data_i),
        .win_open (win_open),
        .refresh  (refresh)
    );

    winwdt_core #(
        .CNT_W (CNT_W)
    ) core_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .blk_rst_n (blk_rst_n),
        .cnt_tick  (cnt_tick),
        .refresh   (refresh),
        .rst_mode  (ufl_rst || prot),
        .init_val  (init_val),
        .cnt_o     (cnt_o),
        .irq_o     (irq_o),
        .rst_req_o (rst_req_o)
    );

endmodule

// File: rtl/winwdt_chk.sv
// Module winwdt_chk
// Property checker for winwdt_top, attached by the bind below.
module winwdt_chk #(
    parameter int CNT_W = 14
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq,
    input logic             rst_req,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] init_val,
    input logic             prot,
    input logic             running,
    input logic             low_power,
    input logic [1:0]       src_sel,
    input logic             wr_en
);

    // R1: the count never goes above the start value.
    a_r1_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= init_val);

    // R5: the interrupt lasts a single cycle.
    a_r5_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R6: the reset request lasts a single cycle.
    a_r6_rstreq_single: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    // R6: after a reset request the count is back at its start value.
    a_r6_reinit: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> (cnt == init_val) && !irq);

    // R5: both underflow outputs never fire together.
    a_r5_one_action: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq && rst_req));

    // R7: with protection held, no interrupt is raised.
    a_r7_prot_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (prot && $past(prot)) |-> !irq);

    // R8: protection stays on until a reset.
    a_r8_prot_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (prot && !rst_req) |=> prot);

    // R4: a system-clock source holds the count in low-power mode.
    a_r4_lp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (running && low_power && !prot && (src_sel != 2'b11) && !wr_en && !rst_req)
        |=> $stable(cnt));

endmodule

bind winwdt_top winwdt_chk #(.CNT_W(CNT_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq       (irq_o),
    .rst_req   (rst_req_o),
    .cnt       (cnt_o),
    .init_val  (init_val),
    .prot      (prot),
    .running   (running),
    .low_power (low_power_i),
    .src_sel   (presc_sel),
    .wr_en     (wr_en_i)
);

// File: tb/winwdt_top_tb_top.sv
module winwdt_top_tb_top;

    localparam int CLK_PERIOD = 10;

    // Vector: init_sel[32:31], win_sel[30:29], start value[28:15], window limit[14:0]
    localparam logic [32:0] VECS [8] = '{
        {2'd0, 2'd0, 14'h03FF, 15'h0100},
        {2'd1, 2'd1, 14'h0FFF, 15'h0800},
        {2'd2, 2'd2, 14'h1FFF, 15'h1800},
        {2'd3, 2'd3, 14'h3FFF, 15'h4000},
        {2'd3, 2'd0, 14'h3FFF, 15'h1000},
        {2'd0, 2'd3, 14'h03FF, 15'h0400},
        {2'd1, 2'd2, 14'h0FFF, 15'h0C00},
        {2'd2, 2'd1, 14'h1FFF, 15'h1000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ls_tick = 1'b0;
    logic        low_power = 1'b0;
    logic        opt_auto = 1'b0;
    logic        opt_prot = 1'b0;
    logic [1:0]  opt_isel = 2'd0;
    logic [1:0]  opt_wsel = 2'd0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [7:0]  wr_data = 8'd0;
    logic [13:0] cnt;
    logic        irq;
    logic        rst_req;

    int n_run  = 0;
    int n_fail = 0;
    int c0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    winwdt_top dut_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .ls_tick_i       (ls_tick),
        .low_power_i     (low_power),
        .opt_autostart_i (opt_auto),
        .opt_prot_i      (opt_prot),
        .opt_init_sel_i  (opt_isel),
        .opt_win_sel_i   (opt_wsel),
        .wr_en_i         (wr_en),
        .wr_addr_i       (wr_addr),
        .wr_data_i       (wr_data),
        .cnt_o           (cnt),
        .irq_o           (irq),
        .rst_req_o       (rst_req)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // All tasks start and end on a falling edge.
    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input logic au, input logic pr, input logic [1:0] is, input logic [1:0] ws);
        rst_n = 1'b0; opt_auto = au; opt_prot = pr; opt_isel = is; opt_wsel = ws;
        ls_tick = 1'b0;
        cycles(2);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        cycles(1);
        wr_en = 1'b0;
    endtask

    task automatic step(input int n);
        ls_tick = 1'b1;
        cycles(n);
        ls_tick = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        n_fail++;
        $display("FAIL watchdog (all requirements): actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R1 / R2: reset state, no counting before the start write
        do_reset(1'b0, 1'b0, 2'd1, 2'd3);
        chk("R1 start value 0FFF", int'(cnt), 'h0FFF);
        chk("R1 irq low", int'(irq), 0);
        chk("R1 rst_req low", int'(rst_req), 0);
        step(40);
        chk("R2 held before start", int'(cnt), 'h0FFF);
        wr(2'd3, 8'hFF);
        cycles(10);
        chk("R12 spare address ignored", int'(cnt), 'h0FFF);
        wr(2'd1, 8'h00);
        cycles(10);
        chk("R3 div2 after start", int'(cnt), 'h0FFF - 5);

        // R3: divide by 16, control bits above 3 ignored (R12)
        do_reset(1'b0, 1'b0, 2'd1, 2'd3);
        wr(2'd2, 8'hF1);
        wr(2'd1, 8'h00);
        cycles(40);
        chk("R3 div16 and R12 high bits", int'(cnt), 'h0FFF - 2);

        // R3: divide by 128
        do_reset(1'b0, 1'b0, 2'd1, 2'd3);
        wr(2'd2, 8'h02);
        wr(2'd1, 8'h00);
        cycles(300);
        chk("R3 div128", int'(cnt), 'h0FFF - 2);

        // R3: low-speed tick divided by 16; R4: keeps counting in low power
        do_reset(1'b0, 1'b0, 2'd1, 2'd3);
        wr(2'd2, 8'h03);
        ls_tick = 1'b1;
        wr(2'd1, 8'h00);
        cycles(50);
        chk("R3 low-speed div16", int'(cnt), 'h0FFF - 3);
        low_power = 1'b1;
        cycles(32);
        chk("R4 low-speed runs in low power", int'(cnt), 'h0FFF - 5);
        ls_tick = 1'b0;

        // R2 auto-start, R4 system source frozen in low power
        low_power = 1'b1;
        do_reset(1'b1, 1'b0, 2'd0, 2'd3);
        cycles(20);
        chk("R4 system source frozen", int'(cnt), 'h03FF);
        low_power = 1'b0;
        cycles(4);
        chk("R2 auto-start after low power", int'(cnt), 'h03FF - 2);

        // R5: interrupt mode underflow
        do_reset(1'b0, 1'b0, 2'd0, 2'd3);
        wr(2'd1, 8'h00);
        cycles(2047);
        chk("R5 count at zero", int'(cnt), 0);
        chk("R5 no irq before underflow", int'(irq), 0);
        cycles(1);
        chk("R5 irq pulse", int'(irq), 1);
        chk("R5 reload after underflow", int'(cnt), 'h03FF);
        chk("R5 no reset request", int'(rst_req), 0);
        cycles(1);
        chk("R5 irq single cycle", int'(irq), 0);
        chk("R5 keeps counting", int'(cnt), 'h03FF);
        cycles(1);
        chk("R5 keeps counting", int'(cnt), 'h03FF - 1);

        // R6: reset mode underflow
        do_reset(1'b0, 1'b0, 2'd0, 2'd3);
        wr(2'd2, 8'h04);
        wr(2'd1, 8'h00);
        cycles(2048);
        chk("R6 reset request", int'(rst_req), 1);
        chk("R6 no irq", int'(irq), 0);
        cycles(1);
        chk("R6 request single cycle", int'(rst_req), 0);
        chk("R6 count reinitialised", int'(cnt), 'h03FF);
        cycles(20);
        chk("R6 running cleared", int'(cnt), 'h03FF);

        // R7 / R8: protection set by software, sticky, undivided low-speed source
        do_reset(1'b1, 1'b0, 2'd0, 2'd3);
        cycles(10);
        wr(2'd2, 8'h08);
        c0 = int'(cnt);
        cycles(20);
        chk("R7 system clock no longer counts", int'(cnt), c0);
        wr(2'd2, 8'h00);
        cycles(20);
        chk("R8 protection not cleared", int'(cnt), c0);
        low_power = 1'b1;
        step(5);
        chk("R7 counts every tick in low power", int'(cnt), c0 - 5);
        step(c0 - 5);
        chk("R7 reaches zero", int'(cnt), 0);
        step(1);
        chk("R7 underflow requests reset", int'(rst_req), 1);
        chk("R7 no irq in protection", int'(irq), 0);
        cycles(1);
        chk("R6 reinit after request", int'(cnt), 'h03FF);
        low_power = 1'b0;
        cycles(4);
        chk("R8 protection cleared by reset", int'(cnt), 'h03FF - 2);

        // R9: key sequence rules, window always open
        do_reset(1'b1, 1'b1, 2'd0, 2'd3);
        step(100);
        chk("R9 counted down", int'(cnt), 'h03FF - 100);
        wr(2'd0, 8'h00);
        wr(2'd0, 8'h55);
        chk("R9 wrong second byte", int'(cnt), 'h03FF - 100);
        wr(2'd0, 8'hFF);
        chk("R9 lone fire byte", int'(cnt), 'h03FF - 100);
        wr(2'd0, 8'h00);
        wr(2'd0, 8'h00);
        wr(2'd0, 8'hFF);
        chk("R9 repeated arm then fire", int'(cnt), 'h03FF);

        // R10 / R11: start values and window limits from the vector table
        for (int i = 0; i < 8; i++) begin
            logic [1:0]  vi;
            logic [1:0]  vw;
            int          vinit;
            int          vthr;
            vi    = VECS[i][32:31];
            vw    = VECS[i][30:29];
            vinit = int'(VECS[i][28:15]);
            vthr  = int'(VECS[i][14:0]);
            do_reset(1'b1, 1'b1, vi, vw);
            chk("R1 table start value", int'(cnt), vinit);
            if (vthr <= vinit) begin
                step(vinit - vthr);
                chk("R10 at window limit", int'(cnt), vthr);
                wr(2'd0, 8'h00);
                wr(2'd0, 8'hFF);
                chk("R10 closed window rejects", int'(cnt), vthr);
                wr(2'd0, 8'h00);
                step(1);
                wr(2'd0, 8'hFF);
                chk("R11 arm outside window discarded", int'(cnt), vthr - 1);
            end else begin
                step(1);
            end
            wr(2'd0, 8'h00);
            wr(2'd0, 8'hFF);
            chk("R10 open window reloads", int'(cnt), vinit);
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule